// File: doc/BRIEF.md
# Windowed Threshold Alert Unit

This block watches the stream of conversion results that leaves a multi-channel scan sequencer. Every result arrives as a one-cycle strobe that carries a channel index and a 12-bit value. The block compares that value with the channel's own upper and lower limits. When the value crosses a limit, it raises a latched flag for that direction and channel.

Each direction has a hysteresis band. A tripped direction keeps setting its flag on every conversion until the value comes back past the limit by the hysteresis amount. The `alert` output is the OR of all latched flags of the channels that are selected for alerting. A host configures and services the block through a simple byte-wide register port. Over that port it sets the limits and hysteresis, picks the alerting channels, enables the comparator, and clears flags by writing 1 to them.

No direction has an enable bit of its own. A direction is silenced by moving its limit to the end of the range: an upper limit of 4095 or a lower limit of 0.

Top module: `thresh_alert_unit`

## Requirements
- R1: After reset, every upper limit reads 4095. For a channel at base B, the byte at B+0 reads 0xF0 and the byte at B+1 reads 0xFF. Every lower limit reads 0 (bytes B+2 and B+3 read 0x00). Hysteresis is 0, both flag registers read 0x00, and `alert` is low.
- R2: Channel c has its limit bytes at base B = 0x10 + 4*c. B+0 bits [7:4] hold upper-limit bits [3:0], and B+1 holds upper-limit bits [11:4]. B+2 bits [7:4] hold lower-limit bits [3:0], and B+3 holds lower-limit bits [11:4]. Bits [3:0] of B+2 are not stored and read as 0.
- R3: Bits [3:0] of byte B+0 hold the 4-bit hysteresis code. They read back independently of the upper-limit nibble in the same byte. The effective hysteresis is the code times 8.
- R4: A result takes part in comparison only when bit 4 of the config register (address 0x00) is 1 and the channel's bit in the select mask (address 0x01) is 1. Any other result leaves the flags unchanged.
- R5: An upper event occurs when the result is strictly greater than the upper limit. It sets bit c of the upper flag register (0x02). A result equal to the limit does not trip.
- R6: A lower event occurs when the result is strictly less than the lower limit. It sets bit c of the lower flag register (0x03).
- R7: A tripped upper direction keeps setting its flag on every compared conversion until a result falls below (upper limit − hysteresis). A tripped lower direction stays tripped until a result rises above (lower limit + hysteresis).
- R8: Writing 1 to a bit of 0x02 or 0x03 clears it, and writing 0 leaves it unchanged. When a clear and a new event hit the same bit in one cycle, the bit stays set.
- R9: Address 0x04 reads, per channel, the OR of the upper and lower flags. Writes to it have no effect.
- R10: `alert` is high whenever any selected channel holds a flag. It rises again after a clear if the value is still beyond the threshold.
- R11: The re-arm points saturate. (upper limit − hysteresis) never goes below 0, and (lower limit + hysteresis) never goes above 4095.
- R12: An upper limit of 4095 never trips, and neither does a lower limit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | CH_W | Channel index of the result |
| res_val | input | 12 | Conversion result |
| alert | output | 1 | OR of the flags of the selected channels |

## Verification
The checker watches the following on every cycle:
- A trip pulse comes only from the strobed, enabled and selected channel.
- A flag never rises without a conversion, and never falls without a write to its flag register.
- Nothing changes while the comparator is off and no write occurs.
- `alert` rises only after a conversion or a register write.

Only the bench's scenarios can show the rest:
- the exact trip and re-arm points, including the equality edge and the saturation of the re-arm points;
- the nibble packing of the limit and hysteresis bytes;
- the persistence of `alert` after a clear.

// File: rtl/thresh_alert_pkg.sv
package thresh_alert_pkg;
  localparam int RES_W      = 12;
  localparam int HYS_W      = 4;
  localparam int HYST_SHIFT = 3;
  localparam logic [RES_W-1:0] RES_MAX = '1;

  localparam logic [7:0] ADDR_CFG  = 8'h00;
  localparam logic [7:0] ADDR_SEL  = 8'h01;
  localparam logic [7:0] ADDR_HIF  = 8'h02;
  localparam logic [7:0] ADDR_LOF  = 8'h03;
  localparam logic [7:0] ADDR_ANY  = 8'h04;
  localparam logic [7:0] LIM_BASE  = 8'h10;
  localparam int         CMP_EN_BIT = 4;

  function automatic logic [RES_W-1:0] hyst_value(input logic [HYS_W-1:0] code);
    return RES_W'(code) << HYST_SHIFT;
  endfunction

  function automatic logic [RES_W-1:0] sat_sub(input logic [RES_W-1:0] a,
                                               input logic [RES_W-1:0] b);
    return (a >= b) ? (a - b) : '0;
  endfunction

  function automatic logic [RES_W-1:0] sat_add(input logic [RES_W-1:0] a,
                                               input logic [RES_W-1:0] b);
    logic [RES_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[RES_W] ? RES_MAX : s[RES_W-1:0];
  endfunction
endpackage

// File: rtl/thresh_alert_limits.sv
module thresh_alert_limits
  import thresh_alert_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic                       lim_hit,
  output logic [7:0]                 lim_rdata,
  output logic [NCH-1:0][RES_W-1:0]  hi_lim,
  output logic [NCH-1:0][RES_W-1:0]  lo_lim,
  output logic [NCH-1:0][HYS_W-1:0]  hyst_code
);
  localparam logic [7:0] LIM_END = 8'(LIM_BASE + 4 * NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [7:0] MY_BASE = 8'(LIM_BASE + 4 * g);
    logic mine;
    assign mine = wr_en && (addr[7:2] == MY_BASE[7:2]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_lim[g]    <= RES_MAX;
        lo_lim[g]    <= '0;
        hyst_code[g] <= '0;
      end else if (mine) begin
        case (addr[1:0])
          2'd0: begin
            hi_lim[g][3:0] <= wdata[7:4];
            hyst_code[g]   <= wdata[3:0];
          end
          2'd1: hi_lim[g][11:4] <= wdata;
          2'd2: lo_lim[g][3:0]  <= wdata[7:4];
          default: lo_lim[g][11:4] <= wdata;
        endcase
      end
    end
  end

  logic [7:0]      rel;
  logic [CH_W-1:0] idx;
  assign lim_hit = (addr >= LIM_BASE) && (addr < LIM_END);
  assign rel     = addr - LIM_BASE;
  assign idx     = CH_W'(rel[7:2]);

  always_comb begin
    lim_rdata = 8'h00;
    if (lim_hit) begin
      case (addr[1:0])
        2'd0:    lim_rdata = {hi_lim[idx][3:0], hyst_code[idx]};
        2'd1:    lim_rdata = hi_lim[idx][11:4];
        2'd2:    lim_rdata = {lo_lim[idx][3:0], 4'h0};
        default: lim_rdata = lo_lim[idx][11:4];
      endcase
    end
  end
endmodule

// File: rtl/thresh_alert_chan.sv
module thresh_alert_chan
  import thresh_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv,
  input  logic [RES_W-1:0] val,
  input  logic [RES_W-1:0] hi_lim,
  input  logic [RES_W-1:0] lo_lim,
  input  logic [HYS_W-1:0] hyst_code,
  output logic             hi_set,
  output logic             lo_set
);
  logic             hi_act_q, lo_act_q, hi_act_d, lo_act_d;
  logic [RES_W-1:0] hy, hi_rearm, lo_rearm;

  assign hy       = hyst_value(hyst_code);
  assign hi_rearm = sat_sub(hi_lim, hy);
  assign lo_rearm = sat_add(lo_lim, hy);

  always_comb begin
    hi_act_d = hi_act_q;
    if (val > hi_lim)        hi_act_d = 1'b1;
    else if (val < hi_rearm) hi_act_d = 1'b0;
    lo_act_d = lo_act_q;
    if (val < lo_lim)        lo_act_d = 1'b1;
    else if (val > lo_rearm) lo_act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_act_q <= 1'b0;
      lo_act_q <= 1'b0;
    end else if (conv) begin
      hi_act_q <= hi_act_d;
      lo_act_q <= lo_act_d;
    end
  end

  assign hi_set = conv & hi_act_d;
  assign lo_set = conv & lo_act_d;
endmodule

// File: rtl/thresh_alert_unit.sv
module thresh_alert_unit
  import thresh_alert_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             res_valid,
  input  logic [CH_W-1:0]  res_ch,
  input  logic [RES_W-1:0] res_val,
  output logic             alert
);
  logic                      cmp_en;
  logic [NCH-1:0]            sel_q, hi_flags, lo_flags, hi_trip, lo_trip;
  logic [NCH-1:0]            hi_clr, lo_clr;
  logic                      lim_hit;
  logic [7:0]                lim_rdata;
  logic [NCH-1:0][RES_W-1:0] hi_lim, lo_lim;
  logic [NCH-1:0][HYS_W-1:0] hyst_code;

  thresh_alert_limits #(.NCH(NCH), .CH_W(CH_W)) lim_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lim_hit(lim_hit), .lim_rdata(lim_rdata),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .hyst_code(hyst_code)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    logic conv_g;
    assign conv_g = res_valid && cmp_en && sel_q[g] && (res_ch == CH_W'(g));
    thresh_alert_chan chan_i (
      .clk(clk), .rst_n(rst_n), .conv(conv_g), .val(res_val),
      .hi_lim(hi_lim[g]), .lo_lim(lo_lim[g]), .hyst_code(hyst_code[g]),
      .hi_set(hi_trip[g]), .lo_set(lo_trip[g])
    );
  end

  assign hi_clr = (wr_en && addr == ADDR_HIF) ? wdata[NCH-1:0] : '0;
  assign lo_clr = (wr_en && addr == ADDR_LOF) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_en   <= 1'b0;
      sel_q    <= '0;
      hi_flags <= '0;
      lo_flags <= '0;
    end else begin
      if (wr_en && addr == ADDR_CFG) cmp_en <= wdata[CMP_EN_BIT];
      if (wr_en && addr == ADDR_SEL) sel_q  <= wdata[NCH-1:0];
      hi_flags <= (hi_flags & ~hi_clr) | hi_trip;
      lo_flags <= (lo_flags & ~lo_clr) | lo_trip;
    end
  end

  always_comb begin
    if (lim_hit) rdata = lim_rdata;
    else begin
      case (addr)
        ADDR_CFG: rdata = 8'(cmp_en) << CMP_EN_BIT;
        ADDR_SEL: rdata = 8'(sel_q);
        ADDR_HIF: rdata = 8'(hi_flags);
        ADDR_LOF: rdata = 8'(lo_flags);
        ADDR_ANY: rdata = 8'(hi_flags | lo_flags);
        default:  rdata = 8'h00;
      endcase
    end
  end

  assign alert = |((hi_flags | lo_flags) & sel_q);
endmodule

// File: rtl/thresh_alert_chk.sv
module thresh_alert_chk
  import thresh_alert_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [7:0]      addr,
  input logic            res_valid,
  input logic [CH_W-1:0] res_ch,
  input logic            cmp_en,
  input logic [NCH-1:0]  hi_flags,
  input logic [NCH-1:0]  lo_flags,
  input logic [NCH-1:0]  hi_trip,
  input logic [NCH-1:0]  lo_trip,
  input logic            alert
);
  // R5: an upper trip comes only from the strobed channel with compare on
  assert_hi_trip_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hi_trip) |-> (res_valid && cmp_en && hi_trip == (NCH'(1) << res_ch)));

  // R6: a lower trip comes only from the strobed channel with compare on
  assert_lo_trip_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|lo_trip) |-> (res_valid && cmp_en && lo_trip == (NCH'(1) << res_ch)));

  // R4: with compare off and no write, the flags hold
  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !wr_en) |=> ($stable(hi_flags) && $stable(lo_flags)));

  // R8: a flag falls only after a write to its own flag register
  assert_hi_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(hi_flags) & ~hi_flags)) |-> ($past(wr_en) && $past(addr) == ADDR_HIF));

  assert_lo_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lo_flags) & ~lo_flags)) |-> ($past(wr_en) && $past(addr) == ADDR_LOF));

  // R10: alert rises only after a conversion or a register write
  assert_alert_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> $past(res_valid || wr_en));
endmodule

bind thresh_alert_unit thresh_alert_chk #(.NCH(NCH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .res_valid(res_valid), .res_ch(res_ch), .cmp_en(cmp_en),
  .hi_flags(hi_flags), .lo_flags(lo_flags),
  .hi_trip(hi_trip), .lo_trip(lo_trip), .alert(alert)
);

// File: tb/thresh_alert_unit_tb_top.sv
`timescale 1ns/1ps
module thresh_alert_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       res_valid = 1'b0;
  logic [2:0] res_ch = 3'd0;
  logic [11:0] res_val = 12'd0;
  logic       alert;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  thresh_alert_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .res_valid(res_valid), .res_ch(res_ch), .res_val(res_val),
    .alert(alert)
  );

  // {channel, value, expect upper flag bit, expect lower flag bit}
  // ch0: upper 2000, lower 500, hysteresis code 2 (16); ch3: upper 1000, lower 100, code 0
  localparam logic [16:0] VEC [12] = '{
    {3'd0, 12'd1500, 1'b0, 1'b0},
    {3'd0, 12'd2000, 1'b0, 1'b0},
    {3'd0, 12'd2001, 1'b1, 1'b0},
    {3'd0, 12'd1990, 1'b1, 1'b0},
    {3'd0, 12'd1983, 1'b0, 1'b0},
    {3'd0, 12'd1990, 1'b0, 1'b0},
    {3'd0, 12'd499,  1'b0, 1'b1},
    {3'd0, 12'd510,  1'b0, 1'b1},
    {3'd0, 12'd517,  1'b0, 1'b0},
    {3'd3, 12'd1001, 1'b1, 1'b0},
    {3'd3, 12'd999,  1'b0, 1'b0},
    {3'd3, 12'd99,   1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic conv(input logic [2:0] c, input logic [11:0] v);
    @(negedge clk);
    res_valid = 1'b1; res_ch = c; res_val = v;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h02, 8'hFF);
    wr(8'h03, 8'hFF);
  endtask

  initial begin
    while (cycles < 50000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, hf, lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, d); check("R1 upper limit byte0", d, 8'hF0);
    rd(8'h11, d); check("R1 upper limit byte1", d, 8'hFF);
    rd(8'h2E, d); check("R1 lower limit byte2 ch7", d, 8'h00);
    rd(8'h2F, d); check("R1 lower limit byte3 ch7", d, 8'h00);
    rd(8'h02, d); check("R1 upper flags", d, 8'h00);
    rd(8'h03, d); check("R1 lower flags", d, 8'h00);
    check("R1 alert", alert, 0);

    // R2/R3 configuration and readback
    wr(8'h10, 8'h02); wr(8'h11, 8'h7D); wr(8'h12, 8'h4F); wr(8'h13, 8'h1F);
    wr(8'h1C, 8'h80); wr(8'h1D, 8'h3E); wr(8'h1E, 8'h40); wr(8'h1F, 8'h06);
    rd(8'h10, d); check("R3 hysteresis code beside limit nibble", d, 8'h02);
    rd(8'h11, d); check("R2 upper limit high byte", d, 8'h7D);
    rd(8'h12, d); check("R2 lower nibble unused bits read 0", d, 8'h40);
    rd(8'h1D, d); check("R2 ch3 upper high byte", d, 8'h3E);
    wr(8'h00, 8'h10); wr(8'h01, 8'hFF);
    rd(8'h00, d); check("R4 config enable bit 4", d, 8'h10);

    // R5 R6 R7 vector table
    for (int i = 0; i < 12; i++) begin
      logic [2:0] c;
      c = VEC[i][16:14];
      conv(c, VEC[i][13:2]);
      rd(8'h02, hf); rd(8'h03, lf);
      check($sformatf("R5/R7 upper flag vec %0d", i), hf[c], VEC[i][1]);
      check($sformatf("R6/R7 lower flag vec %0d", i), lf[c], VEC[i][0]);
      clear_all();
    end

    // R4: comparator off, then channel not selected
    wr(8'h00, 8'h00);
    conv(3'd0, 12'd3000);
    rd(8'h02, d); check("R4 compare off no flag", d, 8'h00);
    wr(8'h00, 8'h10); wr(8'h01, 8'hFE);
    conv(3'd0, 12'd3000);
    rd(8'h02, d); check("R4 unselected channel no flag", d, 8'h00);
    wr(8'h01, 8'hFF);

    // R10 alert persistence, R9 combined register
    conv(3'd3, 12'd1500);
    check("R10 alert on trip", alert, 1);
    rd(8'h04, d); check("R9 combined flags", d, 8'h08);
    wr(8'h04, 8'hFF);
    rd(8'h04, d); check("R9 write to combined ignored", d, 8'h08);
    wr(8'h02, 8'h00);
    rd(8'h02, d); check("R8 writing zero keeps flag", d, 8'h08);
    clear_all();
    check("R10 alert low after clear", alert, 0);
    conv(3'd3, 12'd1500);
    check("R10 alert back while beyond limit", alert, 1);
    wr(8'h01, 8'hF7);
    check("R10 alert masked by select", alert, 0);
    rd(8'h02, d); check("R10 flag kept while masked", d, 8'h08);
    wr(8'h01, 8'hFF);

    // R8 set wins over simultaneous clear
    @(negedge clk);
    res_valid = 1'b1; res_ch = 3'd3; res_val = 12'd1500;
    wr_en = 1'b1; addr = 8'h02; wdata = 8'hFF;
    @(negedge clk);
    res_valid = 1'b0; wr_en = 1'b0;
    rd(8'h02, d); check("R8 event wins over clear", d, 8'h08);
    clear_all();

    // R11 saturation on ch1: upper 5, lower 4050, code 15 (120)
    wr(8'h14, 8'h5F); wr(8'h15, 8'h00); wr(8'h16, 8'h20); wr(8'h17, 8'hFD);
    conv(3'd1, 12'd6); clear_all();
    conv(3'd1, 12'd0);
    rd(8'h02, d); check("R11 upper re-arm floors at 0", d[1], 1);
    clear_all();
    conv(3'd1, 12'd4049); clear_all();
    conv(3'd1, 12'd4095);
    rd(8'h03, d); check("R11 lower re-arm caps at 4095", d[1], 1);
    clear_all();

    // R12 extreme limits on ch2 (defaults)
    conv(3'd2, 12'd4095);
    conv(3'd2, 12'd0);
    rd(8'h04, d); check("R12 extreme limits never trip", d[2], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule